// File: doc/BRIEF.md
# Oversampled SPI Slave Receiver

This block is an SPI slave in mode 0 that runs entirely on a fast system clock. The serial clock, the active-low select and the serial data input arrive from an external master with no timing relation to that clock. Each of the three lines passes through a parameterised flip-flop chain in the system clock domain. Serial clock and select edges are found by comparing the chain output with one further register stage. The serial clock never drives a flop's clock pin, so a slow or noisy slope produces one registered transition and one shift, not two.

While selected, the slave shifts serial input bits into a byte register on each detected serial clock rise, most significant bit first. After every full byte it raises a one-cycle strobe with the received value. In the other direction it loads a byte from an input port when the select falls and again at each byte boundary. It presents that byte on the serial output, most significant bit first, and advances it on detected serial clock falls. The system clock must run at least about four to eight times the serial clock rate.

Top module: `spi_os_slave`

## Requirements
- R1: While and right after reset, `rx_valid_o` is 0, `rx_byte_o` is 0, `miso_oe_o` is 0 and `miso_o` is 0.
- R2: Every real rising edge of `sclk_i` during a selected transfer causes exactly one bit shift. This holds for slow edges and for edges at any phase to the system clock, so N transmitted bytes give exactly N strobes.
- R3: The received byte is assembled most significant bit first from `mosi_i` as sampled at each detected `sclk_i` rise. `rx_byte_o` changes only in a cycle where `rx_valid_o` is 1.
- R4: `rx_valid_o` is high for exactly one system clock cycle per completed 8-bit byte, and only while the slave is selected.
- R5: On a detected falling edge of `csn_i` the slave loads `tx_byte_i`. `miso_o` shows that byte's bit 7 before the first `sclk_i` rise and moves to the next lower bit after each detected `sclk_i` fall.
- R6: At each completed byte the slave reloads `tx_byte_i`. Back-to-back bytes in one selection send each loaded value in full, bit 7 first.
- R7: While `csn_i` is high (after synchronization), `miso_oe_o` is 0 and `miso_o` is 0. Toggles on `sclk_i` are ignored: no strobe occurs and the bit position does not advance.
- R8: A rising edge of `csn_i` in the middle of a byte discards the partial bits without a strobe. The next selection starts again at bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the master, asynchronous |
| csn_i | input | 1 | Active-low select from the master, asynchronous |
| mosi_i | input | 1 | Serial data from the master, asynchronous |
| tx_byte_i | input | DATA_W | Byte to send, taken at select fall and at each byte boundary |
| miso_o | output | 1 | Serial data to the master |
| miso_oe_o | output | 1 | Output enable for `miso_o`, high while selected |
| rx_byte_o | output | DATA_W | Last complete received byte |
| rx_valid_o | output | 1 | One-cycle strobe marking a new `rx_byte_o` |

## Verification
The bench drives serial clock edges at odd phases and at very slow rates. A design that still detected edges on a raw or partly synchronized line would shift twice or miss bits, and the received byte count or value would then be wrong. Idle serial clock toggles with the select high check that the bit counter is frozen: a design that counted them would misalign the next byte. An aborted half-byte is followed by a clean byte, which catches a design that keeps stale bits. Back-to-back bytes check the reload at the boundary, where shifting on the boundary fall would drop the new byte's top bit.

// File: rtl/spi_os_pkg.sv
`timescale 1ns/1ps
package spi_os_pkg;
    // bit positions of the three asynchronous lines inside the synchronizer vector
    localparam int LINE_MOSI = 0;
    localparam int LINE_CSN  = 1;
    localparam int LINE_SCLK = 2;
    localparam int N_LINES   = 3;
    // idle levels: serial clock low, select high (inactive), data low
    localparam logic [N_LINES-1:0] LINE_IDLE = 3'b010;
endpackage

// File: rtl/spi_os_sync.sv
`timescale 1ns/1ps
module spi_os_sync #(
    parameter int           W     = 3,
    parameter int           DEPTH = 2,
    parameter logic [W-1:0] IDLE  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [DEPTH];

    genvar s;
    generate
        for (s = 0; s < DEPTH; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= IDLE;
                end else if (s == 0) begin
                    stage_q[s] <= async_i;
                end else begin
                    stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[DEPTH-1];
endmodule

// File: rtl/spi_os_edge.sv
`timescale 1ns/1ps
module spi_os_edge #(
    parameter int           W    = 2,
    parameter logic [W-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= IDLE;
        else        last_q <= level_i;
    end

    assign rise_o = level_i & ~last_q;
    assign fall_o = ~level_i & last_q;
endmodule

// File: rtl/spi_os_slave.sv
`timescale 1ns/1ps
module spi_os_slave #(
    parameter int DATA_W     = 8,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              csn_i,
    input  logic              mosi_i,
    input  logic [DATA_W-1:0] tx_byte_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              rx_valid_o
);
    import spi_os_pkg::*;

    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] rx_sh;
        logic [DATA_W-1:0] tx_sh;
        logic [DATA_W-1:0] rx_byte;
        logic              rx_valid;
    } core_t;

    core_t q, d;

    logic [N_LINES-1:0] lines_s;
    logic [1:0]         edge_rise, edge_fall;
    logic               sclk_rise, sclk_fall, cs_start, cs_stop, mosi_s;
    logic [DATA_W-1:0]  rx_next;

    spi_os_sync #(.W(N_LINES), .DEPTH(SYNC_DEPTH), .IDLE(LINE_IDLE)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sclk_i, csn_i, mosi_i}),
        .sync_o  (lines_s)
    );

    // bit 1: serial clock, bit 0: select
    spi_os_edge #(.W(2), .IDLE(2'b01)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i ({lines_s[LINE_SCLK], lines_s[LINE_CSN]}),
        .rise_o  (edge_rise),
        .fall_o  (edge_fall)
    );

    assign sclk_rise = edge_rise[1];
    assign sclk_fall = edge_fall[1];
    assign cs_start  = edge_fall[0];
    assign cs_stop   = edge_rise[0];
    assign mosi_s    = lines_s[LINE_MOSI];
    assign rx_next   = {q.rx_sh[DATA_W-2:0], mosi_s};

    always_comb begin
        d          = q;
        d.rx_valid = 1'b0;
        if (cs_start) begin
            d.active = 1'b1;
            d.cnt    = '0;
            d.rx_sh  = '0;
            d.tx_sh  = tx_byte_i;
        end else if (cs_stop) begin
            d.active = 1'b0;
            d.cnt    = '0;
        end else if (q.active) begin
            if (sclk_rise) begin
                d.rx_sh = rx_next;
                if (q.cnt == LAST_BIT) begin
                    d.cnt      = '0;
                    d.rx_byte  = rx_next;
                    d.rx_valid = 1'b1;
                    d.tx_sh    = tx_byte_i;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end else if (sclk_fall && (q.cnt != '0)) begin
                // a fall right after a byte boundary keeps the fresh byte's top bit
                d.tx_sh = {q.tx_sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign miso_oe_o  = q.active;
    assign miso_o     = q.active & q.tx_sh[DATA_W-1];
    assign rx_byte_o  = q.rx_byte;
    assign rx_valid_o = q.rx_valid;
endmodule

// File: rtl/spi_os_slave_chk.sv
`timescale 1ns/1ps
module spi_os_slave_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              miso_o,
    input logic              miso_oe_o,
    input logic [DATA_W-1:0] rx_byte_o,
    input logic              rx_valid_o
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!rx_valid_o && !miso_oe_o && !miso_o));

    assert_byte_changes_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_byte_o != $past(rx_byte_o)) |-> rx_valid_o);

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    assert_strobe_selected_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> miso_oe_o);

    assert_idle_output_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !miso_oe_o |-> !miso_o);
endmodule

bind spi_os_slave spi_os_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .miso_o     (miso_o),
    .miso_oe_o  (miso_oe_o),
    .rx_byte_o  (rx_byte_o),
    .rx_valid_o (rx_valid_o)
);

// File: tb/sim_spi_os_slave.sv
`timescale 1ns/1ps
module sim_spi_os_slave;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0;
    logic         csn = 1'b1;
    logic         mosi = 1'b0;
    logic [W-1:0] tx_byte = '0;
    logic         miso, miso_oe, rx_valid;
    logic [W-1:0] rx_byte;

    int n_chk = 0;
    int n_bad = 0;
    int n_rx  = 0;
    logic [W-1:0] rx_log [64];
    logic prev_v = 1'b0;
    bit done = 0;

    always #10 clk = ~clk;

    spi_os_slave #(.DATA_W(W), .SYNC_DEPTH(2)) u0 (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
        .tx_byte_i(tx_byte), .miso_o(miso), .miso_oe_o(miso_oe),
        .rx_byte_o(rx_byte), .rx_valid_o(rx_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    // strobe monitor, sampled on the falling system clock edge
    always @(negedge clk) begin
        if (rx_valid) begin
            if (n_rx < 64) rx_log[n_rx] = rx_byte;
            n_rx++;
        end
        if (rx_valid && prev_v) chk(0, "R4 strobe wider than one cycle", 1, 0);
        if (rx_valid && !miso_oe) chk(0, "R4 strobe while deselected", 0, 1);
        prev_v = rx_valid;
    end

    // one selected transfer of nb bytes; tx values double as expected miso bits
    task automatic xfer(input logic [W-1:0] mo [4], input logic [W-1:0] so [4],
                        input int nb, input int half);
        int base = n_rx;
        tx_byte = so[0];
        #(half) csn = 1'b0;
        #(2*half);
        chk(miso_oe == 1'b1, "R7 oe after select", miso_oe, 1);
        for (int k = 0; k < nb; k++) begin
            for (int b = W-1; b >= 0; b--) begin
                mosi = mo[k][b];
                #(half);
                chk(miso == so[k][b], (k == 0) ? "R5 miso bit" : "R6 reloaded miso bit", miso, so[k][b]);
                sclk = 1'b1;
                if (b == W-1 && k + 1 < nb) tx_byte = so[k+1];
                #(half) sclk = 1'b0;
            end
        end
        #(half) csn = 1'b1;
        #(3*half);
        chk(n_rx - base == nb, "R2 strobe count", n_rx - base, nb);
        for (int k = 0; k < nb; k++)
            if (base + k < 64)
                chk(rx_log[base+k] == mo[k], "R3 received byte", rx_log[base+k], mo[k]);
        chk(miso_oe == 1'b0 && miso == 1'b0, "R7 outputs after deselect", {miso_oe, miso}, 0);
    endtask

    task automatic t_reset();
        chk(rx_valid == 0, "R1 strobe in reset", rx_valid, 0);
        chk(rx_byte == 0, "R1 byte in reset", rx_byte, 0);
        chk(miso_oe == 0 && miso == 0, "R1 miso in reset", {miso_oe, miso}, 0);
    endtask

    task automatic t_single();
        logic [W-1:0] mo [4] = '{8'hA5, 0, 0, 0};
        logic [W-1:0] so [4] = '{8'h3C, 0, 0, 0};
        xfer(mo, so, 1, 80);
    endtask

    task automatic t_burst_slow();
        logic [W-1:0] mo [4] = '{8'h12, 8'hFE, 8'h80, 8'h01};
        logic [W-1:0] so [4] = '{8'hC3, 8'h5A, 8'h01, 8'hFF};
        xfer(mo, so, 4, 230);
    endtask

    task automatic t_odd_phase();
        logic [W-1:0] mo [4] = '{8'h00, 8'hFF, 8'h81, 0};
        logic [W-1:0] so [4] = '{8'hFF, 8'h00, 8'h7E, 0};
        xfer(mo, so, 3, 97);
    endtask

    task automatic t_idle_clocks();
        logic [W-1:0] mo [4] = '{8'h69, 0, 0, 0};
        logic [W-1:0] so [4] = '{8'h96, 0, 0, 0};
        int base = n_rx;
        for (int i = 0; i < 11; i++) begin
            mosi = i[0];
            #80 sclk = 1'b1;
            #80 sclk = 1'b0;
            chk(miso_oe == 0 && miso == 0, "R7 outputs idle while clocked", {miso_oe, miso}, 0);
        end
        #200;
        chk(n_rx == base, "R7 no strobe while deselected", n_rx - base, 0);
        xfer(mo, so, 1, 80);
    endtask

    task automatic t_abort();
        logic [W-1:0] mo [4] = '{8'hB7, 0, 0, 0};
        logic [W-1:0] so [4] = '{8'hE1, 0, 0, 0};
        int base = n_rx;
        tx_byte = 8'h55;
        #80 csn = 1'b0;
        #160;
        for (int i = 0; i < 3; i++) begin
            mosi = 1'b1;
            #80 sclk = 1'b1;
            #80 sclk = 1'b0;
        end
        #80 csn = 1'b1;
        #400;
        chk(n_rx == base, "R8 no strobe on partial byte", n_rx - base, 0);
        xfer(mo, so, 1, 80);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #3;
        t_reset();
        rst_n = 1'b1;
        #197;
        t_reset();
        t_single();
        t_burst_slow();
        t_odd_phase();
        t_idle_clocks();
        t_abort();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            chk(0, "watchdog expired", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule